// File: doc/BRIEF.md
# LPC Memory Write Target

This block is the target side of memory write transfers on a Low Pin Count bus. Each clock it samples the active-low frame strobe and the 4-bit multiplexed address/data lines. It picks out a start nibble and a memory-write cycle type. It then gathers a 32-bit address and one data byte. After two host turnaround clocks it drives a ready sync and returns the bus through its own turnaround clock.

The shared bidirectional lines are split into three signals: an input, an output value and an output enable. An outside pad drives the wire from the output value while the enable is high. A completed write is presented as a one-clock pulse on `wr_valid`, with `wr_addr` and `wr_data` valid in that same clock. The two capture outputs keep their values until the next completed write.

The block has no handling for other cycle kinds. A cycle type other than memory write, or a frame that is cut short, makes the block wait quietly for the next start. An asynchronous active-low reset stops any transfer in progress.

Top module: `lpc_mwr_target`

## Requirements
- R1: While and after reset, `lad_oe` and `wr_valid` are 0 and `wr_addr`/`wr_data` read 0 until the first completed write.
- R2: A transfer begins only on a clock where `frame_n` is 0 and `lad_in` is 4'b0000. The value 4'b0000 with `frame_n` at 1 starts nothing.
- R3: On the clock after the start, a nibble whose upper three bits are 3'b011 (bit 0 may be 0 or 1) selects a memory write. Any other nibble makes the block ignore the rest of the frame, with `lad_oe` and `wr_valid` held at 0 until a new start.
- R4: The next eight clocks carry the address one nibble each, bits 31:28 first and bits 3:0 last.
- R5: The next two clocks carry the data byte, bits 3:0 first, then bits 7:4.
- R6: `lad_oe` stays 0 from the start clock through the two host turnaround clocks that follow the data. The sync 4'b0000 is driven (`lad_oe`=1) in the clock after the second turnaround clock, which is 14 clocks after the start clock.
- R7: `wr_valid` is high for exactly that sync clock, with `wr_addr` and `wr_data` equal to the captured address and data.
- R8: In the clock after the sync, the block drives 4'b1111 with `lad_oe`=1. In the clock after that, `lad_oe` returns to 0.
- R9: `frame_n` at 0 in the middle of a transfer aborts it. If the nibble on that clock is 4'b0000, a new transfer starts there. Otherwise nothing more happens until the next start.
- R10: Taking `rst_n` low during a transfer aborts it. The remaining nibbles produce no sync and no `wr_valid`.
- R11: A new start on the clock right after the target turnaround clock is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Sampled value of the shared address/data lines |
| lad_out | output | 4 | Value the target drives onto the lines |
| lad_oe | output | 1 | Output enable for `lad_out` |
| wr_valid | output | 1 | One-clock pulse marking a completed memory write |
| wr_addr | output | 32 | Address of the last completed write |
| wr_data | output | 8 | Data byte of the last completed write |

## Verification
If the sequencer counts a phase wrongly, the sync and the `wr_valid` pulse land one or more clocks away from the fourteenth clock after the start. That fault is seen in the first write. If the nibble shifting is wrong, `wr_addr` or `wr_data` comes out with its nibbles swapped or moved, and the sync clock of that same write shows it. If the abort or ignore paths keep state they should drop, a sync appears on the bus during a frame the host has abandoned. That is seen within fourteen clocks of the stray start.

// File: rtl/lpc_mwr_pkg.sv
package lpc_mwr_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] NIB_START   = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC_OK = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_TAR     = 4'b1111;
  localparam logic [2:0]       MWR_PREFIX  = 3'b011;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_DATA,
    ST_HTAR0,
    ST_HTAR1,
    ST_SYNC,
    ST_TTAR,
    ST_SKIP
  } mwr_state_e;

  function automatic logic is_start(input logic frame_n, input logic [NIB_W-1:0] nib);
    return (frame_n == 1'b0) && (nib == NIB_START);
  endfunction

  function automatic logic is_mem_write(input logic [NIB_W-1:0] nib);
    return nib[NIB_W-1:1] == MWR_PREFIX;
  endfunction

endpackage

// File: rtl/lpc_mwr_fsm.sv
module lpc_mwr_fsm
  import lpc_mwr_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int DATA_NIBS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] lad_in,
  output mwr_state_e       state_q,
  output logic             addr_shift,
  output logic             data_shift,
  output logic             start_seen,
  output logic             sync_enter
);

  localparam int MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  mwr_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign start_seen = is_start(frame_n, lad_in);

  always_comb begin
    state_d = state_q;
    if (!frame_n) begin
      state_d = start_seen ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_CTYPE: state_d = is_mem_write(lad_in) ? ST_ADDR : ST_SKIP;
        ST_ADDR:  state_d = (cnt_q == ADDR_LAST) ? ST_DATA : ST_ADDR;
        ST_DATA:  state_d = (cnt_q == DATA_LAST) ? ST_HTAR0 : ST_DATA;
        ST_HTAR0: state_d = ST_HTAR1;
        ST_HTAR1: state_d = ST_SYNC;
        ST_SYNC:  state_d = ST_TTAR;
        ST_TTAR:  state_d = ST_IDLE;
        ST_SKIP:  state_d = ST_SKIP;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_d = '0;
    if ((state_q == ST_ADDR && state_d == ST_ADDR) ||
        (state_q == ST_DATA && state_d == ST_DATA))
      cnt_d = cnt_q + 1'b1;
  end

  assign addr_shift = frame_n && (state_q == ST_ADDR);
  assign data_shift = frame_n && (state_q == ST_DATA);
  assign sync_enter = (state_d == ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/lpc_mwr_capture.sv
module lpc_mwr_capture
  import lpc_mwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  lad_in,
  input  logic              addr_shift,
  input  logic              data_shift,
  input  logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  // address arrives most significant nibble first: shift left, enter at bottom
  function automatic logic [ADDR_W-1:0] addr_push(input logic [ADDR_W-1:0] cur,
                                                  input logic [NIB_W-1:0] nib);
    return {cur[ADDR_W-NIB_W-1:0], nib};
  endfunction

  // data arrives least significant nibble first: shift right, enter at top
  function automatic logic [DATA_W-1:0] data_push(input logic [DATA_W-1:0] cur,
                                                  input logic [NIB_W-1:0] nib);
    return {nib, cur[DATA_W-1:NIB_W]};
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (addr_shift) addr_q <= addr_push(addr_q, lad_in);
      if (data_shift) data_q <= data_push(data_q, lad_in);
      if (commit) begin
        wr_addr <= addr_q;
        wr_data <= data_q;
      end
    end
  end

endmodule

// File: rtl/lpc_mwr_drive.sv
module lpc_mwr_drive
  import lpc_mwr_pkg::*;
(
  input  mwr_state_e       state_q,
  output logic [NIB_W-1:0] lad_out,
  output logic             lad_oe,
  output logic             wr_valid
);

  always_comb begin
    lad_out  = NIB_TAR;
    lad_oe   = 1'b0;
    wr_valid = 1'b0;
    if (state_q == ST_SYNC) begin
      lad_out  = NIB_SYNC_OK;
      lad_oe   = 1'b1;
      wr_valid = 1'b1;
    end else if (state_q == ST_TTAR) begin
      lad_out  = NIB_TAR;
      lad_oe   = 1'b1;
    end
  end

endmodule

// File: rtl/lpc_mwr_target.sv
module lpc_mwr_target
  import lpc_mwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;

  mwr_state_e state_q;
  logic       addr_shift;
  logic       data_shift;
  logic       start_seen;
  logic       sync_enter;

  lpc_mwr_fsm #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .state_q   (state_q),
    .addr_shift(addr_shift),
    .data_shift(data_shift),
    .start_seen(start_seen),
    .sync_enter(sync_enter)
  );

  lpc_mwr_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .lad_in    (lad_in),
    .addr_shift(addr_shift),
    .data_shift(data_shift),
    .commit    (sync_enter),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  lpc_mwr_drive u_drv (
    .state_q (state_q),
    .lad_out (lad_out),
    .lad_oe  (lad_oe),
    .wr_valid(wr_valid)
  );

endmodule

// File: rtl/lpc_mwr_chk.sv
module lpc_mwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       wr_valid,
  input logic       start_seen,
  input logic       sync_enter
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!lad_oe && !wr_valid);
    end
  end

  // R2
  start_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !lad_oe);

  // R6
  sync_follows_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_enter |=> (wr_valid && lad_oe && lad_out == 4'b0000));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R7
  valid_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (lad_oe && lad_out == 4'b0000));

  // R8
  tar_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && frame_n) |=> (lad_oe && lad_out == 4'b1111));

  // R8
  release_after_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && !wr_valid) |=> !lad_oe);

  // R9
  frame_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!lad_oe && !wr_valid));

endmodule

bind lpc_mwr_target lpc_mwr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_n   (frame_n),
  .lad_out   (lad_out),
  .lad_oe    (lad_oe),
  .wr_valid  (wr_valid),
  .start_seen(start_seen),
  .sync_enter(sync_enter)
);

// File: tb/lpc_mwr_target_test.sv
module lpc_mwr_target_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpc_mwr_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic bit exp_mwr(input logic [3:0] t);
    return t[3:1] == 3'b011;
  endfunction

  function automatic logic [3:0] addr_nib(input logic [31:0] a, input int i);
    return a[31 - 4*i -: 4];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge sample, return at the next negedge
  task automatic tick(input logic f, input logic [3:0] l);
    frame_n = f;
    lad_in  = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input string req);
    check(req, {62'd0, lad_oe, wr_valid}, 64'd0);
  endtask

  // full frame; start_ok=0 puts the start nibble out with the frame strobe high
  task automatic write_cycle(input logic [31:0] a, input logic [7:0] d,
                             input logic [3:0] t, input bit start_ok);
    bit ok;
    ok = start_ok && exp_mwr(t);
    tick(!start_ok, 4'h0);               quiet("R2");
    tick(1'b1, t);                       quiet("R3");
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, addr_nib(a, i));        quiet("R4");
    end
    tick(1'b1, d[3:0]);                  quiet("R5");
    tick(1'b1, d[7:4]);                  quiet("R6");
    tick(1'b1, 4'hF);                    quiet("R6");
    tick(1'b1, 4'($urandom));
    if (ok) begin
      check("R6", {60'd0, lad_oe, lad_out}, {60'd0, 1'b1, 4'h0});
      check("R7", {63'd0, wr_valid}, 64'd1);
      check("R4", {32'd0, wr_addr}, {32'd0, a});
      check("R5", {56'd0, wr_data}, {56'd0, d});
    end else begin
      quiet("R3");
    end
    tick(1'b1, 4'($urandom));
    if (ok) begin
      check("R8", {59'd0, wr_valid, lad_oe, lad_out}, {59'd0, 1'b0, 1'b1, 4'hF});
    end else begin
      quiet("R3");
    end
  endtask

  task automatic after_cycle(input string req);
    tick(1'b1, 4'($urandom));
    quiet(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [7:0]  d;
    logic [3:0]  t;
    void'($urandom(32'd20250101));
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {22'd0, lad_oe, wr_valid, wr_addr, wr_data}, 64'd0);
    rst_n = 1'b1;
    tick(1'b1, 4'hF);
    check("R1", {22'd0, lad_oe, wr_valid, wr_addr, wr_data}, 64'd0);

    // directed: both direction bits of the memory-write type
    write_cycle(32'h1234_5678, 8'hA5, 4'b0110, 1'b1);
    after_cycle("R8");
    write_cycle(32'hFEDC_BA98, 8'h3C, 4'b0111, 1'b1);
    after_cycle("R8");

    // R2: start nibble without frame strobe
    write_cycle(32'h0BAD_F00D, 8'h11, 4'b0110, 1'b0);
    check("R2", {32'd0, wr_addr}, {32'd0, 32'hFEDC_BA98});

    // R3: non memory-write type, then recovery
    write_cycle(32'hAAAA_5555, 8'h77, 4'b0100, 1'b1);
    check("R3", {32'd0, wr_addr}, {32'd0, 32'hFEDC_BA98});
    write_cycle(32'h0000_0001, 8'h80, 4'b0110, 1'b1);
    // R11 back-to-back, no idle clock between
    write_cycle(32'h8000_0000, 8'h01, 4'b0111, 1'b1);
    after_cycle("R11");

    // R9: restart with a new start mid-address
    tick(1'b0, 4'h0); tick(1'b1, 4'h6);
    for (int i = 0; i < 3; i++) tick(1'b1, 4'h9);
    write_cycle(32'hC0DE_1234, 8'h5A, 4'b0110, 1'b1);
    after_cycle("R9");

    // R9: frame strobe with non-start nibble during data, rest ignored
    tick(1'b0, 4'h0); tick(1'b1, 4'h6);
    for (int i = 0; i < 8; i++) tick(1'b1, 4'h2);
    tick(1'b1, 4'h3);
    tick(1'b0, 4'h5); quiet("R9");
    for (int i = 0; i < 6; i++) begin
      tick(1'b1, 4'h0); quiet("R9");
    end
    check("R9", {32'd0, wr_addr}, {32'd0, 32'hC0DE_1234});

    // R10: reset mid-address, then the remaining nibbles
    tick(1'b0, 4'h0); tick(1'b1, 4'h6);
    tick(1'b1, 4'h1); tick(1'b1, 4'h2);
    rst_n = 1'b0;
    tick(1'b1, 4'h3); quiet("R10");
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1'b1, 4'h4); quiet("R10");
    end
    check("R10", {32'd0, wr_addr}, 64'd0);

    // constrained random frames with idle gaps
    for (int n = 0; n < 60; n++) begin
      a = $urandom;
      d = 8'($urandom);
      t = ($urandom_range(0, 3) == 0) ? 4'($urandom) : {3'b011, 1'($urandom)};
      write_cycle(a, d, t, 1'b1);
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
        tick(1'b1, 4'($urandom)); quiet("R2");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule